// File: doc/BRIEF.md
# Five-Stage Pipeline Stage-Enable Sequencer

This block follows instruction classes through a fixed, in-order pipeline of five stages: fetch, decode, execute, memory and writeback. Each clock it may take in one instruction-class token. The token then moves forward exactly one stage per clock. The block never holds a token in place. From what each stage holds, it drives the functional-unit enables that a datapath would use: instruction-memory read, register read, ALU, branch evaluation, data-memory read or write, and register write. It also reports whether the pipeline is filling, full or draining, and it counts the instructions that leave writeback.

Every class passes through all five stages. Where a class has no work in a stage, that stage is an empty slot for it. Because of this, each shared unit is driven from one fixed stage only. The clearest case is the register-file write port, which belongs to the fifth stage alone.

The input is a valid/ready stream. A token is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low only while reset is applied, so the block never applies back-pressure in normal operation. The upstream side may hold `in_valid` high on every cycle. A cycle without a valid token enters the pipeline as a bubble.

Top module: `pipe_stage_seq`

## Requirements
- R1: A token taken at a clock edge occupies stage 0 (fetch) in the following cycle. It then moves up one stage per clock through 1 (decode), 2 (execute), 3 (memory) and 4 (writeback). `stage_occ` bit i is high while stage i holds an instruction.
- R2: Any instruction in stage 0 asserts `imem_rd_en`. Any instruction in stage 1 asserts `reg_rd_en`. Any instruction in stage 2 asserts `alu_en`.
- R3: A load (class code 3'b001) asserts `dmem_rd_en` in stage 3 and `reg_wr_en` in stage 4.
- R4: A store (class code 3'b010) asserts `dmem_wr_en` in stage 3 and asserts nothing in stage 4.
- R5: An R-type instruction (class code 3'b011) asserts no data-memory enable in stage 3 and asserts `reg_wr_en` in stage 4.
- R6: A branch (class code 3'b100) asserts `br_eval_en` together with `alu_en` in stage 2, and asserts nothing in stages 3 and 4.
- R7: `reg_wr_en` is driven only from stage 4. It stays low in the cycle where a register-writing instruction sits in stage 3.
- R8: Class code 3'b000, codes 3'b101 to 3'b111, and cycles with `in_valid` low all enter the pipeline as bubbles. A bubble sets no `stage_occ` bit and asserts no enable.
- R9: N back-to-back instructions complete in N+4 cycles. `retire` is high in the fifth cycle after the first instruction is taken, and again in each of the following N-1 cycles.
- R10: `full` is high when all five stages are occupied. `filling` is high when a valid instruction token is presented and at least one stage is empty. `draining` is high when no valid instruction token is presented and at least one stage is occupied.
- R11: `retire_cnt` goes up by one at each clock edge where stage 4 holds an instruction, and wraps modulo 2^CNT_W.
- R12: `in_ready` is low while `rst` is high and high otherwise. A token presented during reset is not taken.
- R13: A synchronous active-high `rst` clears every stage and `retire_cnt`, even while instructions are in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Token present on `in_class` |
| in_class | input | 3 | Instruction class: 000 bubble, 001 load, 010 store, 011 R-type, 100 branch |
| in_ready | output | 1 | Token accepted when high together with `in_valid` |
| imem_rd_en | output | 1 | Instruction-memory read enable (stage 0) |
| reg_rd_en | output | 1 | Register-file read enable (stage 1) |
| alu_en | output | 1 | ALU enable (stage 2) |
| br_eval_en | output | 1 | Branch outcome evaluation (stage 2) |
| dmem_rd_en | output | 1 | Data-memory read enable (stage 3) |
| dmem_wr_en | output | 1 | Data-memory write enable (stage 3) |
| reg_wr_en | output | 1 | Register-file write enable (stage 4) |
| stage_occ | output | 5 | Per-stage occupancy, bit i for stage i |
| full | output | 1 | All stages occupied |
| filling | output | 1 | Valid token presented while a stage is empty |
| draining | output | 1 | No valid token while a stage is occupied |
| retire | output | 1 | Stage 4 holds an instruction this cycle |
| retire_cnt | output | CNT_W | Retired-instruction count |

## Verification
The bench builds the block with CNT_W set to 4. With that setting, the retired-instruction counter wraps after sixteen completions, and a run of ordinary length reaches the wrap. Every other property of the block is independent of the parameter: the stage count is fixed at five, so the fill, full and drain windows and the per-class enable schedule are the same as at the default width. Back-to-back streams of six and of ten tokens are long enough to hold the pipeline full for several cycles between filling and draining.

// File: rtl/pss_pkg.sv
package pss_pkg;

  localparam int NSTAGE = 5;
  localparam int CLS_W  = 3;

  localparam int ST_FE = 0;
  localparam int ST_DE = 1;
  localparam int ST_EX = 2;
  localparam int ST_MA = 3;
  localparam int ST_WR = 4;

  typedef enum logic [CLS_W-1:0] {
    CLS_NONE   = 3'b000,
    CLS_LOAD   = 3'b001,
    CLS_STORE  = 3'b010,
    CLS_ALU    = 3'b011,
    CLS_BRANCH = 3'b100
  } cls_e;

  typedef struct packed {
    logic vld;
    cls_e cls;
  } slot_t;

  typedef struct packed {
    logic imem_rd;
    logic reg_rd;
    logic alu;
    logic br_eval;
    logic dmem_rd;
    logic dmem_wr;
    logic reg_wr;
  } unit_en_t;

  // Turn a raw token into a pipeline slot; unknown codes become bubbles.
  function automatic slot_t classify(input logic v, input logic [CLS_W-1:0] c);
    slot_t s;
    s.vld = 1'b0;
    s.cls = CLS_NONE;
    if (v) begin
      case (c)
        3'b001, 3'b010, 3'b011, 3'b100: begin
          s.vld = 1'b1;
          s.cls = cls_e'(c);
        end
        default: ;
      endcase
    end
    return s;
  endfunction

endpackage

// File: rtl/pss_stage_chain.sv
module pss_stage_chain
  import pss_pkg::*;
#(
  parameter int DEPTH = NSTAGE
) (
  input  logic                   clk,
  input  logic                   rst,
  input  slot_t                  in_slot,
  output slot_t [DEPTH-1:0]      stage_q
);

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    slot_t nxt;
    if (i == 0) begin : g_head
      assign nxt = in_slot;
      AST_HEAD_LOAD: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> stage_q[0] == $past(in_slot)); // R1
    end else begin : g_body
      assign nxt = stage_q[i-1];
      AST_SHIFT_ONE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> stage_q[i] == $past(stage_q[i-1])); // R1
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        stage_q[i].vld <= 1'b0;
        stage_q[i].cls <= CLS_NONE;
      end else begin
        stage_q[i] <= nxt;
      end
    end
  end

endmodule

// File: rtl/pss_unit_decode.sv
module pss_unit_decode
  import pss_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  slot_t [NSTAGE-1:0]     stage_q,
  output unit_en_t               en
);

  slot_t fe, de, ex, ma, wr;
  assign fe = stage_q[ST_FE];
  assign de = stage_q[ST_DE];
  assign ex = stage_q[ST_EX];
  assign ma = stage_q[ST_MA];
  assign wr = stage_q[ST_WR];

  always_comb begin
    en         = '0;
    en.imem_rd = fe.vld;
    en.reg_rd  = de.vld;
    en.alu     = ex.vld;
    en.br_eval = ex.vld && (ex.cls == CLS_BRANCH);
    en.dmem_rd = ma.vld && (ma.cls == CLS_LOAD);
    en.dmem_wr = ma.vld && (ma.cls == CLS_STORE);
    en.reg_wr  = wr.vld && ((wr.cls == CLS_LOAD) || (wr.cls == CLS_ALU));
  end

  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!fe.vld && !de.vld && !ex.vld && !ma.vld && !wr.vld) |-> (en == '0)); // R8
  AST_BRANCH_IN_EX: assert property (@(posedge clk) disable iff (rst)
    en.br_eval |-> en.alu); // R6
  AST_MEM_ONE_OP: assert property (@(posedge clk) disable iff (rst)
    $onehot0({en.dmem_rd, en.dmem_wr})); // R3

endmodule

// File: rtl/pss_occ_status.sv
module pss_occ_status
  import pss_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  slot_t                  in_slot,
  input  slot_t [NSTAGE-1:0]     stage_q,
  output logic [NSTAGE-1:0]      occ,
  output logic                   full,
  output logic                   filling,
  output logic                   draining,
  output logic                   retire,
  output logic [CNT_W-1:0]       retire_cnt
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  for (genvar i = 0; i < NSTAGE; i++) begin : g_occ
    assign occ[i] = stage_q[i].vld;
  end

  assign full     = &occ;
  assign filling  = in_slot.vld && !full;
  assign draining = !in_slot.vld && (|occ);
  assign retire   = occ[ST_WR];

  always_ff @(posedge clk) begin
    if (rst)         retire_cnt <= '0;
    else if (retire) retire_cnt <= retire_cnt + CNT_ONE;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    retire |=> retire_cnt == $past(retire_cnt) + CNT_ONE); // R11
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !retire |=> $stable(retire_cnt)); // R11
  AST_FULL_NOT_FILLING: assert property (@(posedge clk) disable iff (rst)
    full |-> !filling); // R10

endmodule

// File: rtl/pipe_stage_seq.sv
module pipe_stage_seq
  import pss_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        in_class,
  output logic              in_ready,
  output logic              imem_rd_en,
  output logic              reg_rd_en,
  output logic              alu_en,
  output logic              br_eval_en,
  output logic              dmem_rd_en,
  output logic              dmem_wr_en,
  output logic              reg_wr_en,
  output logic [4:0]        stage_occ,
  output logic              full,
  output logic              filling,
  output logic              draining,
  output logic              retire,
  output logic [CNT_W-1:0]  retire_cnt
);

  slot_t                 in_slot;
  slot_t [NSTAGE-1:0]    stage_q;
  unit_en_t              en;

  assign in_ready = !rst;
  assign in_slot  = classify(in_valid && in_ready, in_class);

  pss_stage_chain #(.DEPTH(NSTAGE)) u_chain (
    .clk     (clk),
    .rst     (rst),
    .in_slot (in_slot),
    .stage_q (stage_q)
  );

  pss_unit_decode u_dec (
    .clk     (clk),
    .rst     (rst),
    .stage_q (stage_q),
    .en      (en)
  );

  pss_occ_status #(.CNT_W(CNT_W)) u_stat (
    .clk        (clk),
    .rst        (rst),
    .in_slot    (in_slot),
    .stage_q    (stage_q),
    .occ        (stage_occ),
    .full       (full),
    .filling    (filling),
    .draining   (draining),
    .retire     (retire),
    .retire_cnt (retire_cnt)
  );

  assign imem_rd_en = en.imem_rd;
  assign reg_rd_en  = en.reg_rd;
  assign alu_en     = en.alu;
  assign br_eval_en = en.br_eval;
  assign dmem_rd_en = en.dmem_rd;
  assign dmem_wr_en = en.dmem_wr;
  assign reg_wr_en  = en.reg_wr;

  AST_REGWR_AFTER_MEM: assert property (@(posedge clk) disable iff (rst)
    reg_wr_en |-> $past(stage_occ[ST_MA])); // R7
  AST_FETCH_FOLLOWS_TOKEN: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_class == 3'b011) |=> imem_rd_en); // R2

endmodule

// File: tb/pipe_stage_seq_test.sv
`timescale 1ns/1ps
module pipe_stage_seq_test;

  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [2:0]    in_class = 3'b000;
  logic          in_ready;
  logic          imem_rd_en, reg_rd_en, alu_en, br_eval_en;
  logic          dmem_rd_en, dmem_wr_en, reg_wr_en;
  logic [4:0]    stage_occ;
  logic          full, filling, draining, retire;
  logic [CW-1:0] retire_cnt;

  int total = 0;
  int bad   = 0;
  int exp_cnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pipe_stage_seq #(.CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_class(in_class),
    .in_ready(in_ready), .imem_rd_en(imem_rd_en), .reg_rd_en(reg_rd_en),
    .alu_en(alu_en), .br_eval_en(br_eval_en), .dmem_rd_en(dmem_rd_en),
    .dmem_wr_en(dmem_wr_en), .reg_wr_en(reg_wr_en), .stage_occ(stage_occ),
    .full(full), .filling(filling), .draining(draining), .retire(retire),
    .retire_cnt(retire_cnt)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Enable vector order: imem, regrd, alu, br, dmrd, dmwr, regwr
  function automatic logic [6:0] exp_en(input logic [2:0] c, input int s);
    case (s)
      0: return 7'b1000000;
      1: return 7'b0100000;
      2: return (c == 3'b100) ? 7'b0011000 : 7'b0010000;
      3: return (c == 3'b001) ? 7'b0000100 : (c == 3'b010) ? 7'b0000010 : 7'b0;
      4: return (c == 3'b001 || c == 3'b011) ? 7'b0000001 : 7'b0;
      default: return 7'b0;
    endcase
  endfunction

  function automatic logic [31:0] en_vec();
    return {25'd0, imem_rd_en, reg_rd_en, alu_en, br_eval_en, dmem_rd_en, dmem_wr_en, reg_wr_en};
  endfunction

  task automatic put(input logic v, input logic [2:0] c);
    in_valid = v;
    in_class = c;
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1; in_class = 3'b001;
    @(negedge clk);
    check("R12 ready low in reset", {31'd0, in_ready}, 32'd0);
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b0; in_class = 3'b000;
    @(negedge clk);
    check("R13 occ after reset", {27'd0, stage_occ}, 32'd0);
    check("R13 cnt after reset", {28'd0, retire_cnt}, 32'd0);
    check("R12 ready after reset", {31'd0, in_ready}, 32'd1);
    check("R8 enables idle", en_vec(), 32'd0);
    exp_cnt = 0;
  endtask

  task automatic t_walk(input logic [2:0] c, input string req);
    put(1'b1, c);
    for (int s = 0; s < 5; s++) begin
      check({req, " R1 occ"}, {27'd0, stage_occ}, 32'd1 << s);
      check({req, " R2 enables"}, en_vec(), {25'd0, exp_en(c, s)});
      if (s == 3) check("R7 no regwr in stage 3", {31'd0, reg_wr_en}, 32'd0);
      if (s == 4) check("R9 retire in stage 4", {31'd0, retire}, 32'd1);
      put(1'b0, 3'b000);
    end
    exp_cnt++;
    check({req, " R11 count"}, {28'd0, retire_cnt}, exp_cnt % 16);
    check({req, " R8 drained"}, en_vec(), 32'd0);
  endtask

  task automatic t_bubbles();
    logic [3:0] codes [4] = '{4'b1000, 4'b1101, 4'b1111, 4'b0011};
    for (int k = 0; k < 4; k++) begin
      put(codes[k][3], codes[k][2:0]);
      check("R8 bubble occ", {27'd0, stage_occ}, 32'd0);
      check("R8 bubble enables", en_vec(), 32'd0);
    end
    put(1'b0, 3'b000);
    put(1'b0, 3'b000);
    check("R8 bubble no retire", {28'd0, retire_cnt}, exp_cnt % 16);
  endtask

  task automatic t_stream(input logic [2:0] c, input int n);
    for (int k = 1; k <= n + 5; k++) begin
      logic [4:0] occ;
      occ = '0;
      for (int j = 1; j <= n; j++)
        if (k - j >= 0 && k - j <= 4) occ[k - j] = 1'b1;
      if (k <= n) put(1'b1, c); else put(1'b0, 3'b000);
      check("R1 stream occ", {27'd0, stage_occ}, {27'd0, occ});
      check("R10 full", {31'd0, full}, {31'd0, occ == 5'h1f});
      check("R10 filling", {31'd0, filling}, {31'd0, (k <= n) && occ != 5'h1f});
      check("R10 draining", {31'd0, draining}, {31'd0, (k > n) && occ != 0});
      check("R9 retire window", {31'd0, retire}, {31'd0, occ[4]});
    end
    exp_cnt += n;
    check("R11 stream count", {28'd0, retire_cnt}, exp_cnt % 16);
  endtask

  task automatic t_midreset();
    put(1'b1, 3'b001);
    put(1'b1, 3'b011);
    put(1'b1, 3'b010);
    rst = 1'b1;
    @(negedge clk);
    check("R13 occ cleared", {27'd0, stage_occ}, 32'd0);
    check("R13 cnt cleared", {28'd0, retire_cnt}, 32'd0);
    check("R12 token ignored in reset", en_vec(), 32'd0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    check("R13 stays empty", {27'd0, stage_occ}, 32'd0);
    exp_cnt = 0;
  endtask

  initial begin
    for (int cyc = 0; cyc < 100000 && !done; cyc++) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_walk(3'b001, "R3 load");
    t_walk(3'b010, "R4 store");
    t_walk(3'b011, "R5 rtype");
    t_walk(3'b100, "R6 branch");
    t_bubbles();
    t_stream(3'b011, 6);
    t_stream(3'b001, 10);
    t_midreset();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule